// File: doc/BRIEF.md
# Two's-Complement Adder-Subtractor with Carry and Overflow Flags

This block is a purely combinational integer arithmetic unit. One control bit picks between addition and subtraction of two equal-width operands. Both operations share one ripple-carry adder. In subtract mode each bit of the second operand is inverted on its way into the adder, and the same control bit supplies the carry into the lowest stage. This gives the two's-complement difference without a separate subtractor.

Two flags come with the result. The carry flag is for unsigned arithmetic: in add mode it is the end carry, and in subtract mode it reads 1 when no borrow occurred. The overflow flag is for signed arithmetic. It is derived by comparing the carry that enters the sign stage with the carry that leaves it. A caller uses whichever flag matches how it interprets the operands.

Top module: `addsub_unit`

## Requirements
- R1: With `mode_sub` = 0, `sum_out` equals (`a_in` + `b_in`) modulo 2^WIDTH.
- R2: With `mode_sub` = 1, `sum_out` equals (`a_in` - `b_in`) modulo 2^WIDTH, formed as `a_in` + inverted `b_in` + 1.
- R3: With `mode_sub` = 0, `carry_out` is 1 exactly when the unsigned sum `a_in` + `b_in` is at least 2^WIDTH.
- R4: With `mode_sub` = 1, `carry_out` is 1 when `a_in` >= `b_in` as unsigned numbers (no borrow) and 0 when a borrow occurred; 0 - 0 gives `carry_out` = 1.
- R5: `ovf_out` is 1 exactly when the true signed result of the selected operation, with both operands read as two's complement, lies outside [-2^(WIDTH-1), 2^(WIDTH-1)-1].
- R6: The end carry is never taken as signed overflow: at WIDTH 8, 0xFF + 0x01 gives `sum_out` 0x00, `carry_out` 1, `ovf_out` 0.
- R7: At WIDTH 8, adding 70 and 80 gives `sum_out` 0x96 with `ovf_out` 1 and `carry_out` 0.
- R8: At WIDTH 8, 0x00 minus 0x80 (the most negative value) gives `sum_out` 0x80, `ovf_out` 1 and `carry_out` 0.
- R9: R1 to R5 hold for any WIDTH of 2 or more. They are checked over every input combination at WIDTH 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | WIDTH | First operand (minuend in subtract mode) |
| b_in | input | WIDTH | Second operand (subtrahend in subtract mode) |
| mode_sub | input | 1 | 0 selects addition, 1 selects subtraction |
| sum_out | output | WIDTH | Result modulo 2^WIDTH |
| carry_out | output | 1 | Unsigned end carry; in subtract mode 1 means no borrow |
| ovf_out | output | 1 | Signed overflow indication |

## Verification
The bound checker compares the outputs with arithmetic on the ports. It assumes every operand and mode bit is a fully known 0 or 1, and it skips any evaluation in which an input is unknown. The stimulus keeps to this assumption. It drives only defined values: the directed corner cases are literal constants, and each random operand is drawn from `$urandom` and cut to the port width. The narrow instance is driven over its whole input space, and the default-width instance gets random vectors and the sign-boundary corners.

// File: rtl/addsub_pkg.sv
package addsub_pkg;

    typedef enum logic {
        OP_ADD = 1'b0,
        OP_SUB = 1'b1
    } op_mode_e;

    localparam int MIN_WIDTH = 2;

endpackage

// File: rtl/addsub_operand_xor.sv
module addsub_operand_xor #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] raw_b,
    input  logic             invert,
    output logic [WIDTH-1:0] cond_b
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_xor
        assign cond_b[i] = raw_b[i] ^ invert;
    end

endmodule

// File: rtl/addsub_ripple.sv
module addsub_ripple #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             carry_into_msb,
    output logic             carry_from_msb
);

    logic [WIDTH:0] chain;

    assign chain[0] = cin;

    for (genvar i = 0; i < WIDTH; i++) begin : g_stage
        logic prop;
        logic gen;
        assign prop       = opa[i] ^ opb[i];
        assign gen        = opa[i] & opb[i];
        assign sum[i]     = prop ^ chain[i];
        assign chain[i+1] = gen | (prop & chain[i]);
    end

    assign carry_into_msb = chain[WIDTH-1];
    assign carry_from_msb = chain[WIDTH];

endmodule

// File: rtl/addsub_flags.sv
module addsub_flags (
    input  logic c_in_sign,
    input  logic c_out_sign,
    output logic carry_flag,
    output logic ovf_flag
);

    assign carry_flag = c_out_sign;
    assign ovf_flag   = c_in_sign ^ c_out_sign;

endmodule

// File: rtl/addsub_unit.sv
module addsub_unit
    import addsub_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    input  logic             mode_sub,
    output logic [WIDTH-1:0] sum_out,
    output logic             carry_out,
    output logic             ovf_out
);

    localparam int SIGN_BIT = WIDTH - 1;

    op_mode_e         op_sel;
    logic             inject;
    logic [WIDTH-1:0] b_cond;
    logic             c_sign_in;
    logic             c_sign_out;

    assign op_sel = op_mode_e'(mode_sub);

    always_comb begin
        unique case (op_sel)
            OP_ADD:  inject = 1'b0;
            OP_SUB:  inject = 1'b1;
            default: inject = 1'b0;
        endcase
    end

    addsub_operand_xor #(.WIDTH(WIDTH)) u_bxor (
        .raw_b  (b_in),
        .invert (inject),
        .cond_b (b_cond)
    );

    addsub_ripple #(.WIDTH(WIDTH)) u_chain (
        .opa            (a_in),
        .opb            (b_cond),
        .cin            (inject),
        .sum            (sum_out),
        .carry_into_msb (c_sign_in),
        .carry_from_msb (c_sign_out)
    );

    addsub_flags u_flags (
        .c_in_sign  (c_sign_in),
        .c_out_sign (c_sign_out),
        .carry_flag (carry_out),
        .ovf_flag   (ovf_out)
    );

    if (SIGN_BIT < MIN_WIDTH - 1) begin : g_width_guard
        $error("addsub_unit: WIDTH below minimum");
    end

endmodule

// File: rtl/addsub_unit_chk.sv
module addsub_unit_chk #(
    parameter int WIDTH = 8
) (
    input logic [WIDTH-1:0] a_in,
    input logic [WIDTH-1:0] b_in,
    input logic             mode_sub,
    input logic [WIDTH-1:0] sum_out,
    input logic             carry_out,
    input logic             ovf_out
);

    localparam int MSB = WIDTH - 1;

    logic [WIDTH:0]   wide_add;
    logic [WIDTH-1:0] diff;
    logic             sgn_ovf;
    logic             known;

    always_comb begin
        wide_add = {1'b0, a_in} + {1'b0, b_in};
        diff     = a_in - b_in;
        known    = !$isunknown({a_in, b_in, mode_sub});
        if (mode_sub)
            sgn_ovf = (a_in[MSB] != b_in[MSB]) && (sum_out[MSB] != a_in[MSB]);
        else
            sgn_ovf = (a_in[MSB] == b_in[MSB]) && (sum_out[MSB] != a_in[MSB]);
    end

    always_comb begin
        if (known) begin
            AST_ADD_RESULT: assert (mode_sub || {carry_out, sum_out} == wide_add); // R1
            AST_SUB_RESULT: assert (!mode_sub || sum_out == diff); // R2
            AST_ADD_CARRY: assert (mode_sub || carry_out == wide_add[WIDTH]); // R3
            AST_SUB_NO_BORROW: assert (!mode_sub || carry_out == (a_in >= b_in)); // R4
            AST_SIGNED_OVF: assert (ovf_out == sgn_ovf); // R5
        end
    end

endmodule

bind addsub_unit addsub_unit_chk #(.WIDTH(WIDTH)) u_addsub_chk (
    .a_in      (a_in),
    .b_in      (b_in),
    .mode_sub  (mode_sub),
    .sum_out   (sum_out),
    .carry_out (carry_out),
    .ovf_out   (ovf_out)
);

// File: tb/tb_addsub_unit.sv
module tb_addsub_unit;

    localparam int W  = 8;
    localparam int NW = 3;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic [W-1:0]  a, b, s;
    logic          m, c, v;
    logic [NW-1:0] na, nb, ns;
    logic          nm, nc, nv;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    addsub_unit #(.WIDTH(W)) dut (
        .a_in(a), .b_in(b), .mode_sub(m),
        .sum_out(s), .carry_out(c), .ovf_out(v)
    );

    addsub_unit #(.WIDTH(NW)) dut_narrow (
        .a_in(na), .b_in(nb), .mode_sub(nm),
        .sum_out(ns), .carry_out(nc), .ovf_out(nv)
    );

    function automatic longint exp_sum(int w, longint x, longint y, bit sub);
        longint md = longint'(1) << w;
        if (sub) return (x - y + md) % md;
        return (x + y) % md;
    endfunction

    function automatic bit exp_carry(int w, longint x, longint y, bit sub);
        longint md = longint'(1) << w;
        if (sub) return x >= y;
        return (x + y) >= md;
    endfunction

    function automatic bit exp_ovf(int w, longint x, longint y, bit sub);
        longint md = longint'(1) << w;
        longint hf = md / 2;
        longint sx = (x >= hf) ? x - md : x;
        longint sy = (y >= hf) ? y - md : y;
        longint r  = sub ? sx - sy : sx + sy;
        return (r >= hf) || (r < -hf);
    endfunction

    task automatic compare(string tag, string what, longint act, longint expv);
        checks++;
        if (act != expv) begin
            failures++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, expv);
        end
    endtask

    task automatic check_vec(int w, longint x, longint y, bit sub,
                             longint act_s, bit act_c, bit act_v, string tag);
        compare(tag, "sum",   act_s, exp_sum(w, x, y, sub));
        compare(tag, "carry", longint'(act_c), longint'(exp_carry(w, x, y, sub)));
        compare(tag, "ovf",   longint'(act_v), longint'(exp_ovf(w, x, y, sub)));
    endtask

    task automatic run_wide(logic [W-1:0] x, logic [W-1:0] y, bit sub, string tag);
        @(posedge clk);
        a <= x; b <= y; m <= sub;
        @(negedge clk);
        check_vec(W, longint'(x), longint'(y), sub, longint'(s), c, v, tag);
    endtask

    task automatic run_lit(logic [W-1:0] x, logic [W-1:0] y, bit sub,
                           logic [W-1:0] es, bit ec, bit ev, string tag);
        @(posedge clk);
        a <= x; b <= y; m <= sub;
        @(negedge clk);
        compare(tag, "sum",   longint'(s), longint'(es));
        compare(tag, "carry", longint'(c), longint'(ec));
        compare(tag, "ovf",   longint'(v), longint'(ev));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired before stimulus finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        a = '0; b = '0; m = 1'b0;
        na = '0; nb = '0; nm = 1'b0;
        void'($urandom(32'd20240611));
        repeat (2) @(posedge clk);

        // initial state with zero operands, R1
        run_lit(8'h00, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0, "R1 zero");
        run_lit(8'd70, 8'd80, 1'b0, 8'h96, 1'b0, 1'b1, "R7 70+80");
        run_lit(8'h00, 8'h80, 1'b1, 8'h80, 1'b0, 1'b1, "R8 0-min");
        run_lit(8'hFF, 8'h01, 1'b0, 8'h00, 1'b1, 1'b0, "R6 end carry");
        run_lit(8'h00, 8'h00, 1'b1, 8'h00, 1'b1, 1'b0, "R4 0-0");
        run_lit(8'h05, 8'h07, 1'b1, 8'hFE, 1'b0, 1'b0, "R4 borrow");
        run_lit(8'h07, 8'h05, 1'b1, 8'h02, 1'b1, 1'b0, "R4 no borrow");
        run_lit(8'h7F, 8'h01, 1'b0, 8'h80, 1'b0, 1'b1, "R5 pos ovf");
        run_lit(8'h80, 8'h80, 1'b0, 8'h00, 1'b1, 1'b1, "R5 neg ovf");
        run_lit(8'h80, 8'h01, 1'b1, 8'h7F, 1'b1, 1'b1, "R5 sub ovf");
        run_lit(8'hC8, 8'h64, 1'b0, 8'h2C, 1'b1, 1'b0, "R3 carry");
        run_lit(8'h33, 8'h11, 1'b1, 8'h22, 1'b1, 1'b0, "R2 diff");

        for (int i = 0; i < 3000; i++) begin
            logic [W-1:0] rx, ry;
            bit rm;
            rx = W'($urandom);
            ry = W'($urandom);
            rm = 1'($urandom);
            if (i % 10 == 0) ry = (i % 20 == 0) ? 8'h80 : 8'h7F;
            run_wide(rx, ry, rm, rm ? "R2 R4 R5 random" : "R1 R3 R5 random");
        end

        // exhaustive narrow width, R9
        for (int mm = 0; mm < 2; mm++) begin
            for (int xa = 0; xa < (1 << NW); xa++) begin
                for (int yb = 0; yb < (1 << NW); yb++) begin
                    @(posedge clk);
                    na <= NW'(xa); nb <= NW'(yb); nm <= 1'(mm);
                    @(negedge clk);
                    check_vec(NW, longint'(xa), longint'(yb), 1'(mm),
                              longint'(ns), nc, nv, "R9 narrow");
                end
            end
        end

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule